// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets logic running on a single clock read and write an external asynchronous static RAM of 512K bytes. The RAM has a 19-bit address, an 8-bit data bus and three active-low strobes (chip select, write strobe and output enable). The controller turns each host request into a sequence of strobe states. Each state is held for a whole number of clock cycles. That number is the ceiling of a nanosecond limit divided by the clock period `CLK_NS`, with a minimum of one cycle.

The host pushes requests on a valid/ready channel. A request carries an address, write data and a write flag. Back-pressure rule: `req_ready` is high only while the controller is idle, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The host must keep the request fields stable until that edge. Each accepted request produces exactly one `rsp_valid` pulse, one cycle long, and the host cannot stall it. For a read, `rsp_rdata` holds the captured byte in that same cycle.

The shared data bus is given as three separate signals: an output byte, a registered drive enable, and an input byte. The pad or the testbench merges them into the tri-state bus. With `CLK_NS` = 5, a read keeps the strobes active for 4 cycles and then waits 2 cycles before the bus may be driven. A write holds the write strobe low for 5 cycles: 2 with the bus released, then 3 with data driven. One hold cycle follows, with the write strobe high and chip select and data still held.

Top module: `sram_link`

## Requirements
- R1: During reset and right after it, mem_ce_n, mem_we_n and mem_oe_n are all 1, mem_dq_oe is 0 and req_ready is 1.
- R2: req_ready is 1 only when no access is in progress. After a request is accepted, req_ready stays 0 until that access has fully finished.
- R3: A read holds mem_ce_n=0, mem_oe_n=0, mem_we_n=1 and a constant mem_addr for at least max(ceil(20/CLK_NS), ceil(10/CLK_NS)) cycles before mem_dq_in is captured. The returned byte equals the last byte written to that address, or 0 if the address was never written.
- R4: mem_we_n stays low for at least ceil(20/CLK_NS) consecutive cycles per write, and mem_oe_n stays 1 throughout.
- R5: After mem_we_n falls, mem_dq_oe stays 0 for ceil(10/CLK_NS) cycles. The write data is then driven for at least ceil(15/CLK_NS) cycles before mem_we_n rises.
- R6: After mem_we_n rises, the write data, mem_addr and mem_ce_n=0 are held for at least max(ceil(2/CLK_NS), ceil(5/CLK_NS)) cycles. mem_we_n is high for at least that long before the next write.
- R7: After a read, mem_dq_oe stays 0 for at least ceil(10/CLK_NS) cycles after mem_oe_n goes high.
- R8: Every accepted request gives exactly one rsp_valid pulse of one cycle, and responses come in request order.
- R9: mem_we_n and mem_oe_n are never 0 at the same time.
- R10: While mem_ce_n stays 0, mem_addr does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid after a read |
| mem_addr | output | 19 | RAM address |
| mem_ce_n | output | 1 | RAM chip select, active low |
| mem_we_n | output | 1 | RAM write strobe, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_dq_out | output | 8 | Byte to drive onto the RAM data bus |
| mem_dq_oe | output | 1 | Drive enable for mem_dq_out |
| mem_dq_in | input | 8 | Byte read from the RAM data bus |

## Verification
The bench models the RAM and tracks, at every falling clock edge, how long each strobe state has lasted.

- **Shortened read window.** A controller that samples the bus too early is caught by the length check on the read window. It is also caught by read-back mismatches against a shadow copy.
- **Write timing.** A write strobe released too soon, or data driven before the contention wait ends, shows up in the low-strobe and drive-run counters.
- **Missing hold cycle.** If data or chip select is dropped on the edge where the strobe rises, the model stores nothing valid, or the hold check fails.
- **Address extremes and turnaround.** The sequence reaches address 0 and the top address, and overwrites one location. It issues back-to-back requests while the host keeps `req_valid` high, and follows a read directly with a write. A missing bus turnaround would drive the bus while the RAM still does.

// File: rtl/sram_link_pkg.sv
package sram_link_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_TURN,
    ST_WR_WAIT,
    ST_WR_DRIVE,
    ST_WR_HOLD
  } link_state_t;

  // ceiling of ns / clk_ns, never below one cycle
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_link_timer.sv
module sram_link_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          done
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/sram_link_fsm.sv
module sram_link_fsm
  import sram_link_pkg::*;
#(
  parameter int TW     = 4,
  parameter int N_RD   = 4,
  parameter int N_TURN = 2,
  parameter int N_WLQZ = 2,
  parameter int N_DS   = 3,
  parameter int N_WH   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  output logic          req_ready,
  output logic          accept,
  output logic          capture,
  output logic          rsp_valid,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe
);
  link_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        tmr_load = 1'b1;
        if (req_write) begin
          state_d = ST_WR_WAIT;
          tmr_val = TW'(N_WLQZ - 1);
        end else begin
          state_d = ST_RD;
          tmr_val = TW'(N_RD - 1);
        end
      end
      ST_RD: if (tmr_done) begin
        state_d  = ST_RD_TURN;
        tmr_load = 1'b1;
        tmr_val  = TW'(N_TURN - 1);
      end
      ST_RD_TURN: if (tmr_done) state_d = ST_IDLE;
      ST_WR_WAIT: if (tmr_done) begin
        state_d  = ST_WR_DRIVE;
        tmr_load = 1'b1;
        tmr_val  = TW'(N_DS - 1);
      end
      ST_WR_DRIVE: if (tmr_done) begin
        state_d  = ST_WR_HOLD;
        tmr_load = 1'b1;
        tmr_val  = TW'(N_WH - 1);
      end
      ST_WR_HOLD: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign capture   = (state_q == ST_RD) && tmr_done;

  // strobes registered from the next state: glitch-free at the pins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      ce_n      <= 1'b1;
      we_n      <= 1'b1;
      oe_n      <= 1'b1;
      dq_oe     <= 1'b0;
      rsp_valid <= 1'b0;
    end else begin
      state_q   <= state_d;
      ce_n      <= (state_d == ST_IDLE) || (state_d == ST_RD_TURN);
      we_n      <= !((state_d == ST_WR_WAIT) || (state_d == ST_WR_DRIVE));
      oe_n      <= (state_d != ST_RD);
      dq_oe     <= (state_d == ST_WR_DRIVE) || (state_d == ST_WR_HOLD);
      rsp_valid <= capture || ((state_q == ST_WR_DRIVE) && tmr_done);
    end
  end
endmodule

// File: rtl/sram_link_dp.sv
module sram_link_dp #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      dq_out <= '0;
      rdata  <= '0;
    end else begin
      if (accept) begin
        addr   <= req_addr;
        dq_out <= req_wdata;
      end
      if (capture) rdata <= dq_in;
    end
  end
endmodule

// File: rtl/sram_link.sv
module sram_link
  import sram_link_pkg::*;
#(
  parameter int AW        = 19,
  parameter int DW        = 8,
  parameter int CLK_NS    = 5,
  parameter int T_AA_NS   = 20,
  parameter int T_OEV_NS  = 10,
  parameter int T_OFF_NS  = 10,
  parameter int T_WP_NS   = 20,
  parameter int T_WLQZ_NS = 10,
  parameter int T_DS_NS   = 15,
  parameter int T_DH_NS   = 2,
  parameter int T_WREC_NS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_we_n,
  output logic          mem_oe_n,
  output logic [DW-1:0] mem_dq_out,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_in
);
  localparam int N_RD   = imax(ns_to_cyc(T_AA_NS, CLK_NS), ns_to_cyc(T_OEV_NS, CLK_NS));
  localparam int N_TURN = ns_to_cyc(T_OFF_NS, CLK_NS);
  localparam int N_WLQZ = ns_to_cyc(T_WLQZ_NS, CLK_NS);
  localparam int N_WP   = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int N_DS   = imax(ns_to_cyc(T_DS_NS, CLK_NS), imax(N_WP - N_WLQZ, 1));
  localparam int N_WH   = imax(ns_to_cyc(T_DH_NS, CLK_NS), ns_to_cyc(T_WREC_NS, CLK_NS));
  localparam int N_MAX  = imax(imax(N_RD, N_TURN), imax(imax(N_WLQZ, N_DS), N_WH));
  localparam int TW     = $clog2(N_MAX + 1);

  logic          tmr_load, tmr_done, accept, capture;
  logic [TW-1:0] tmr_val;

  sram_link_timer #(.TW(TW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
  );

  sram_link_fsm #(
    .TW(TW), .N_RD(N_RD), .N_TURN(N_TURN), .N_WLQZ(N_WLQZ), .N_DS(N_DS), .N_WH(N_WH)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .tmr_done(tmr_done), .tmr_load(tmr_load), .tmr_val(tmr_val),
    .req_ready(req_ready), .accept(accept), .capture(capture), .rsp_valid(rsp_valid),
    .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n), .dq_oe(mem_dq_oe)
  );

  sram_link_dp #(.AW(AW), .DW(DW)) u_dp (
    .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
    .req_addr(req_addr), .req_wdata(req_wdata), .dq_in(mem_dq_in),
    .addr(mem_addr), .dq_out(mem_dq_out), .rdata(rsp_rdata)
  );
endmodule

// File: rtl/sram_link_chk.sv
module sram_link_chk #(
  parameter int AW     = 19,
  parameter int N_WP   = 4,
  parameter int N_WLQZ = 2,
  parameter int N_TURN = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          we_n,
  input logic          oe_n,
  input logic          dq_oe,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] addr
);
  logic [7:0] we_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= 8'd0;
      oe_hi_cnt <= 8'hFF;
    end else begin
      if (!we_n) we_lo_cnt <= (we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1;
      else       we_lo_cnt <= 8'd0;
      if (!oe_n) oe_hi_cnt <= 8'd0;
      else       oe_hi_cnt <= (oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1;
    end
  end

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (ce_n && we_n && oe_n && !dq_oe)); // R1
  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> ce_n); // R2
  AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) $rose(we_n) |-> (we_lo_cnt >= 8'(N_WP))); // R4
  AST_WE_OE_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (!we_n) |-> oe_n); // R4
  AST_DRIVE_WAIT: assert property (@(posedge clk) disable iff (!rst_n) (dq_oe && !we_n) |-> (we_lo_cnt >= 8'(N_WLQZ))); // R5
  AST_BUS_TURN: assert property (@(posedge clk) disable iff (!rst_n) dq_oe |-> (oe_hi_cnt >= 8'(N_TURN))); // R7
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |=> !rsp_valid); // R8
  AST_NO_WE_OE: assert property (@(posedge clk) disable iff (!rst_n) !(!we_n && !oe_n)); // R9
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!ce_n && $past(!ce_n)) |-> $stable(addr)); // R10
endmodule

bind sram_link sram_link_chk #(
  .AW(AW), .N_WP(N_WP), .N_WLQZ(N_WLQZ), .N_TURN(N_TURN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ce_n(mem_ce_n), .we_n(mem_we_n), .oe_n(mem_oe_n),
  .dq_oe(mem_dq_oe), .req_ready(req_ready), .rsp_valid(rsp_valid), .addr(mem_addr)
);

// File: tb/sim_sram_link.sv
`timescale 1ns/1ps
module sim_sram_link;
  localparam int CK     = 5;
  localparam int E_RD   = (20 + CK - 1) / CK;
  localparam int E_WP   = (20 + CK - 1) / CK;
  localparam int E_WLQZ = (10 + CK - 1) / CK;
  localparam int E_DS   = (15 + CK - 1) / CK;
  localparam int E_TURN = (10 + CK - 1) / CK;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic req_ready, rsp_valid, mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0] rsp_rdata, mem_dq_out;
  logic [7:0] model_q = 8'h00;
  logic [18:0] mem_addr;

  always #2.5 clk = ~clk;

  sram_link u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(model_q)
  );

  int checks = 0, bad = 0, n_req = 0, n_rsp = 0;
  bit finished = 0;
  int exp_q[$];
  logic [7:0] shadow [int];
  logic [7:0] ram [int];

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  endtask

  // RAM model and strobe observer
  int we_low_run = 0, drv_run = 0, rd_run = 0, last_rd_run = 0, oe_high_run = 99;
  logic prev_we = 1'b1, prev_ce = 1'b1;
  logic [18:0] prev_addr = '0;
  bit rd_act;

  always @(negedge clk) if (rst_n) begin
    rd_act = !mem_ce_n && !mem_oe_n && mem_we_n;
    if (!mem_we_n && !mem_oe_n) chk(0, "R9", 0, 1);
    if (!mem_ce_n && !prev_ce && mem_addr != prev_addr) chk(0, "R10", int'(mem_addr), int'(prev_addr));
    if (mem_dq_oe) begin
      chk(oe_high_run >= E_TURN && !rd_act, "R7", oe_high_run, E_TURN);
      if (!mem_we_n && drv_run == 0) chk(we_low_run >= E_WLQZ, "R5", we_low_run, E_WLQZ);
    end
    if (!prev_we && mem_we_n) begin
      chk(we_low_run >= E_WP, "R4", we_low_run, E_WP);
      chk(drv_run >= E_DS, "R5", drv_run, E_DS);
      chk(mem_dq_oe && !mem_ce_n && mem_addr == prev_addr, "R6", int'(mem_dq_oe), 1);
      ram[int'(mem_addr)] = mem_dq_out;
    end
    if (!mem_we_n) chk(mem_oe_n, "R4", int'(mem_oe_n), 1);
    if (!mem_we_n) we_low_run++; else we_low_run = 0;
    if (!mem_we_n && mem_dq_oe) drv_run++; else drv_run = 0;
    if (!mem_oe_n) oe_high_run = 0; else if (oe_high_run < 99) oe_high_run++;
    if (rd_act) begin
      rd_run = (rd_run > 0 && mem_addr != prev_addr) ? 1 : rd_run + 1;
      model_q <= ram.exists(int'(mem_addr)) ? ram[int'(mem_addr)] : 8'h00;
    end else begin
      if (rd_run > 0) last_rd_run = rd_run;
      rd_run = 0;
      model_q <= 8'h00;
    end
    // scoreboard monitor
    if (rsp_valid) begin
      n_rsp++;
      if (exp_q.size() == 0) chk(0, "R8", n_rsp, n_req);
      else begin
        int e;
        e = exp_q.pop_front();
        if (e < 256) begin
          chk(last_rd_run >= E_RD, "R3", last_rd_run, E_RD);
          chk(rsp_rdata == 8'(e), "R3", int'(rsp_rdata), e);
        end
      end
    end
    prev_we = mem_we_n; prev_ce = mem_ce_n; prev_addr = mem_addr;
  end

  // driver: pushes expected responses, then holds the request until taken
  task automatic req(input bit w, input int a, input int d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = 19'(a); req_wdata = 8'(d);
    if (w) shadow[a] = 8'(d);
    exp_q.push_back(w ? 256 : (shadow.exists(a) ? int'(shadow[a]) : 0));
    n_req++;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(!req_ready, "R2", int'(req_ready), 0);
  endtask

  initial begin
    #(200000 * CK);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n, "R1", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    chk(!mem_dq_oe, "R1", int'(mem_dq_oe), 0);
    chk(req_ready, "R1", int'(req_ready), 1);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1", {mem_ce_n, mem_we_n, mem_oe_n}, 7);
    req(1, 0, 8'h5A);
    req(1, 19'h7FFFF, 8'hC3);
    req(1, 19'h12345, 8'hFF);
    req(0, 0, 0);
    req(0, 19'h7FFFF, 0);
    req(0, 19'h12345, 0);
    req(1, 19'h12345, 8'h00);   // overwrite
    req(0, 19'h12345, 0);
    req(0, 19'h00100, 0);       // never written: reads 0
    for (int i = 0; i < 8; i++) req(1, 19'h40000 + i * 3, (i * 37 + 1) & 255);
    for (int i = 7; i >= 0; i--) req(0, 19'h40000 + i * 3, 0);
    for (int i = 0; i < 4; i++) begin   // read followed directly by write
      req(0, 19'h40000 + i * 3, 0);
      req(1, 19'h40000 + i * 3, 8'hA0 + i);
    end
    for (int i = 0; i < 4; i++) req(0, 19'h40000 + i * 3, 0);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 0 && n_rsp == n_req, "R8", n_rsp, n_req);
    finish_run();
  end
endmodule